// File: doc/BRIEF.md
# Sequencer Microcode RAM Loader

This block holds the instruction memory of an embedded sequencer and gives a host access to it through a narrow register port. The port has four byte-wide registers: a control register, a low and a high word-address register, and a data window. The host sets the load enable in the control register and writes a start word address. It then streams bytes into the data window. The block packs each group of four bytes, least significant byte first, into one 32-bit instruction word. It commits that word to memory when the fourth byte arrives and then moves to the next word address.

The same data window reads the memory back in the same byte order. The control register also drives the sequencer's run-time controls: a hold-in-reset bit, a single-step bit, a fast-mode bit and a parity-check-disable bit. The sequencer fetch port has a program counter. That counter advances on a request from the sequencer. It is cleared by the reset bit and frozen while loading is enabled.

Host requests use a valid/ready handshake. `req_ready` is always high, so the block never applies back-pressure, and a request is accepted on every clock edge where `req_valid` is high. Each accepted read yields exactly one `rsp_valid` pulse with its byte on the following cycle. The response path has no ready signal, so the host must take the byte in that cycle.

Top module: `ucode_loader`

## Requirements
- R1: After reset the control register, the word address and the byte position are zero, `rsp_valid` is low and `seq_pc` is zero.
- R2: A control write keeps only bit 0 (load enable), bit 1 (sequencer reset), bit 2 (single step), bit 4 (fast mode) and bit 7 (parity-check disable). The other bits read back as 0. Bits 1, 2, 4 and 7 drive `seq_reset`, `seq_step`, `seq_fast` and `seq_perr_dis` directly.
- R3: Register select 2 is the low 8 bits of the word address. Register select 3 holds the remaining upper address bits in its low bits, which is bit 0 only at the default 9-bit width. All other bits of select 3 read as 0.
- R4: While load is enabled, four successive writes to the data window (select 1) form one word, with the first byte in bits 7:0 and the fourth in bits 31:24. The word is written to memory at the current address when the fourth byte is accepted.
- R5: The word address stays unchanged after the first three data bytes and increments by one after the fourth.
- R6: The word address wraps from its maximum value to 0.
- R7: Writing either address register returns the byte position to 0, so the next data byte becomes the least significant byte of a word.
- R8: Data-window writes while load enable is clear change neither the memory, the address nor the byte position.
- R9: Data-window reads return the addressed word's bytes least significant first. They share the byte position with writes, and the address increments after the fourth read.
- R10: While the sequencer reset bit is set, `seq_pc` is cleared on each clock edge. The memory contents are kept.
- R11: `seq_instr` shows the word at `seq_pc`. `seq_pc` increments on `seq_advance` only while both load enable and sequencer reset are clear.
- R12: `req_ready` is always 1. `rsp_valid` is high exactly in the cycle after an accepted read, carrying that read's byte, and is never high after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 control, 1 data window, 2 address low, 3 address high |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid, one cycle after an accepted read |
| rsp_data | output | 8 | Read response byte |
| seq_advance | input | 1 | Sequencer request to step the program counter |
| seq_pc | output | ADDR_W | Sequencer program counter |
| seq_instr | output | 32 | Instruction word at `seq_pc` |
| seq_reset | output | 1 | Sequencer hold-in-reset control |
| seq_step | output | 1 | Single-step control |
| seq_fast | output | 1 | Fast-mode control |
| seq_perr_dis | output | 1 | Parity-check-disable control |

## Verification
The bench uses the default 9-bit word address and four bytes per word. With these values the upper address register is a single bit, and the top word (511) can be addressed directly. That makes the wrap to word 0 reachable with one four-byte burst. It also exercises the split of the address between the two registers.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ALO  = 2'd2,
    SEL_AHI  = 2'd3
  } reg_sel_e;

  localparam int CTL_LOAD = 0;
  localparam int CTL_RST  = 1;
  localparam int CTL_STEP = 2;
  localparam int CTL_FAST = 4;
  localparam int CTL_PERR = 7;
  localparam logic [7:0] CTL_MASK = 8'h97;
endpackage

// File: rtl/ucode_ctrl_reg.sv
module ucode_ctrl_reg
  import ucode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic       load_en,
  output logic       seq_rst,
  output logic       step,
  output logic       fast,
  output logic       perr_dis
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & CTL_MASK;
  end

  assign load_en  = q[CTL_LOAD];
  assign seq_rst  = q[CTL_RST];
  assign step     = q[CTL_STEP];
  assign fast     = q[CTL_FAST];
  assign perr_dis = q[CTL_PERR];
endmodule

// File: rtl/ucode_word_ptr.sv
module ucode_word_ptr #(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  localparam int HI_W  = ADDR_W - 8,
  localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  bsel,
  output logic              last
);
  assign last = (bsel == CNT_W'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      bsel <= '0;
    end else if (ld_lo) begin
      addr[7:0] <= wdata;
      bsel      <= '0;
    end else if (ld_hi) begin
      addr[ADDR_W-1:8] <= wdata[HI_W-1:0];
      bsel             <= '0;
    end else if (step) begin
      if (last) begin
        bsel <= '0;
        addr <= addr + 1'b1;
      end else begin
        bsel <= bsel + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ucode_pack_mem.sv
module ucode_pack_mem #(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              wr_byte,
  input  logic              last,
  input  logic [CNT_W-1:0]  bsel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rd_word,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] fetch_word
);
  logic [BYTE_W-1:0] hold [BYTES];
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign new_word[i*BYTE_W +: BYTE_W] = (bsel == CNT_W'(i)) ? wdata : hold[i];
    always_ff @(posedge clk) begin
      if (wr_byte && bsel == CNT_W'(i)) hold[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte && last) mem[addr] <= new_word;
  end

  assign rd_word    = mem[addr];
  assign fetch_word = mem[fetch_addr];
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
  import ucode_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  localparam int WORD_W = BYTES * 8,
  localparam int HI_W   = ADDR_W - 8,
  localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              seq_advance,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [WORD_W-1:0] seq_instr,
  output logic              seq_reset,
  output logic              seq_step,
  output logic              seq_fast,
  output logic              seq_perr_dis
);
  logic              acc, wr, rd, data_wr, data_rd;
  logic [7:0]        ctrl_q;
  logic              load_en;
  logic [ADDR_W-1:0] word_addr;
  logic [CNT_W-1:0]  bsel;
  logic              last;
  logic [WORD_W-1:0] rd_word;
  logic [7:0]        rd_byte;

  assign req_ready = 1'b1;
  assign acc     = req_valid && req_ready;
  assign wr      = acc && req_write;
  assign rd      = acc && !req_write;
  assign data_wr = wr && (req_sel == SEL_DATA) && load_en;
  assign data_rd = rd && (req_sel == SEL_DATA);

  ucode_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we(wr && req_sel == SEL_CTRL), .wdata(req_wdata),
    .q(ctrl_q), .load_en(load_en), .seq_rst(seq_reset),
    .step(seq_step), .fast(seq_fast), .perr_dis(seq_perr_dis)
  );

  ucode_word_ptr #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_lo(wr && req_sel == SEL_ALO), .ld_hi(wr && req_sel == SEL_AHI),
    .wdata(req_wdata), .step(data_wr || data_rd),
    .addr(word_addr), .bsel(bsel), .last(last)
  );

  ucode_pack_mem #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(8)) u_mem (
    .clk(clk), .wr_byte(data_wr), .last(last), .bsel(bsel),
    .wdata(req_wdata), .addr(word_addr), .rd_word(rd_word),
    .fetch_addr(seq_pc), .fetch_word(seq_instr)
  );

  assign rd_byte = rd_word[bsel*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) begin
        unique case (reg_sel_e'(req_sel))
          SEL_CTRL: rsp_data <= ctrl_q;
          SEL_DATA: rsp_data <= rd_byte;
          SEL_ALO:  rsp_data <= word_addr[7:0];
          SEL_AHI:  rsp_data <= 8'(word_addr[ADDR_W-1 -: HI_W]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || seq_reset)          seq_pc <= '0;
    else if (!load_en && seq_advance) seq_pc <= seq_pc + 1'b1;
  end
endmodule

// File: rtl/ucode_loader_chk.sv
module ucode_loader_chk
  import ucode_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_sel,
  input logic              rsp_valid,
  input logic              seq_advance,
  input logic [ADDR_W-1:0] seq_pc,
  input logic              seq_reset,
  input logic              load_en,
  input logic [ADDR_W-1:0] word_addr
);
  p_rsp_follows_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);
  p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == SEL_DATA && !load_en) |=> $stable(word_addr));
  p_pc_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset |=> (seq_pc == '0));
  p_pc_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !seq_reset) |=> $stable(seq_pc));
  p_pc_steps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !seq_reset && seq_advance) |=> (seq_pc == ADDR_W'($past(seq_pc) + 1'b1)));
endmodule

bind ucode_loader ucode_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_sel(req_sel), .rsp_valid(rsp_valid),
  .seq_advance(seq_advance), .seq_pc(seq_pc), .seq_reset(seq_reset),
  .load_en(load_en), .word_addr(word_addr)
);

// File: tb/tb_ucode_loader.sv
module tb_ucode_loader;
  localparam int AW = 9;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [1:0] req_sel = 0;
  logic [7:0] req_wdata = 0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic seq_advance = 0;
  logic [AW-1:0] seq_pc;
  logic [31:0] seq_instr;
  logic seq_reset, seq_step, seq_fast, seq_perr_dis;
  int total = 0, bad = 0, reads = 0, resps = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ucode_loader #(.ADDR_W(AW), .BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .seq_advance(seq_advance),
    .seq_pc(seq_pc), .seq_instr(seq_instr), .seq_reset(seq_reset),
    .seq_step(seq_step), .seq_fast(seq_fast), .seq_perr_dis(seq_perr_dis)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] s, input logic [7:0] d);
    req_valid = 1; req_write = w; req_sel = s; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    bus(1'b1, s, d);
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reads++;
    bus(1'b0, s, 8'h00);
  endtask

  // monitor: pops expected bytes as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      resps++;
      if (exp_q.size() == 0) chk("R12 unexpected rsp_valid", 32'(rsp_data), 32'hxx);
      else chk(tag_q.pop_front(), 32'(rsp_data), 32'(exp_q.pop_front()));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 seq_pc", 32'(seq_pc), 0);
    chk("R12 req_ready", 32'(req_ready), 1);
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd2, 8'h00, "R1 addr lo");

    wr(2'd0, 8'hFF);
    chk("R12 no rsp after write", 32'(rsp_valid), 0);
    chk("R2 outputs", {28'h0, seq_reset, seq_step, seq_fast, seq_perr_dis}, 32'hF);
    rd(2'd0, 8'h97, "R2 ctrl mask");
    wr(2'd0, 8'h01);
    chk("R2 reset bit off", 32'(seq_reset), 0);

    wr(2'd2, 8'h10); wr(2'd3, 8'hFF);
    rd(2'd3, 8'h01, "R3 addr hi");
    rd(2'd2, 8'h10, "R3 addr lo");

    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    rd(2'd2, 8'h10, "R5 no advance after 3 bytes");
    wr(2'd1, 8'h44);
    rd(2'd2, 8'h11, "R5 advance after 4th");

    wr(2'd2, 8'h10);
    rd(2'd1, 8'h11, "R4 R9 byte0"); rd(2'd1, 8'h22, "R4 R9 byte1");
    rd(2'd1, 8'h33, "R4 R9 byte2"); rd(2'd1, 8'h44, "R4 R9 byte3");
    rd(2'd2, 8'h11, "R9 advance after 4th read");

    wr(2'd3, 8'h00); wr(2'd2, 8'h20);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    wr(2'd2, 8'h20);
    wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03); wr(2'd1, 8'h04);
    wr(2'd2, 8'h20);
    rd(2'd1, 8'h01, "R7 byte0"); rd(2'd1, 8'h02, "R7 byte1");
    rd(2'd1, 8'h03, "R7 byte2"); rd(2'd1, 8'h04, "R7 byte3");

    wr(2'd3, 8'h01); wr(2'd2, 8'hFF);
    wr(2'd1, 8'h5A); wr(2'd1, 8'h6B); wr(2'd1, 8'h7C); wr(2'd1, 8'h8D);
    rd(2'd2, 8'h00, "R6 wrap lo"); rd(2'd3, 8'h00, "R6 wrap hi");
    wr(2'd3, 8'h01); wr(2'd2, 8'hFF);
    rd(2'd1, 8'h5A, "R6 top word b0"); rd(2'd1, 8'h6B, "R6 top word b1");
    rd(2'd1, 8'h7C, "R6 top word b2"); rd(2'd1, 8'h8D, "R6 top word b3");

    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00); wr(2'd2, 8'h20);
    for (int i = 0; i < 4; i++) wr(2'd1, 8'hEE);
    rd(2'd2, 8'h20, "R8 addr unchanged");
    rd(2'd1, 8'h01, "R8 word kept b0"); rd(2'd1, 8'h02, "R8 word kept b1");
    rd(2'd1, 8'h03, "R8 word kept b2"); rd(2'd1, 8'h04, "R8 word kept b3");

    wr(2'd0, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hEF); wr(2'd1, 8'hBE); wr(2'd1, 8'hAD); wr(2'd1, 8'hDE);
    wr(2'd1, 8'h78); wr(2'd1, 8'h56); wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    wr(2'd0, 8'h00);
    chk("R11 instr at pc0", seq_instr, 32'hDEADBEEF);
    seq_advance = 1; @(posedge clk); @(negedge clk); seq_advance = 0;
    chk("R11 pc step", 32'(seq_pc), 1);
    chk("R11 instr at pc1", seq_instr, 32'h12345678);
    wr(2'd0, 8'h01);
    seq_advance = 1; repeat (2) begin @(posedge clk); @(negedge clk); end seq_advance = 0;
    chk("R11 pc frozen while loading", 32'(seq_pc), 1);
    wr(2'd0, 8'h02);
    @(negedge clk);
    chk("R10 pc cleared", 32'(seq_pc), 0);
    chk("R10 reset output", 32'(seq_reset), 1);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    rd(2'd1, 8'h78, "R10 ram kept b0"); rd(2'd1, 8'h56, "R10 ram kept b1");
    rd(2'd1, 8'h34, "R10 ram kept b2"); rd(2'd1, 8'h12, "R10 ram kept b3");

    repeat (3) @(negedge clk);
    chk("R12 one response per read", 32'(resps), 32'(reads));
    finish_run();
  end
endmodule